// File: doc/BRIEF.md
# Multiplexed LED Scanner with Dimming

This block drives a common-cathode panel of five digits by ten segments. Each clock is one sub-tick of the scan. Sixteen sub-ticks make one slot, and six slots make one frame. Slots 0 to 4 each light one grid. Slot 5 lights nothing and is left free for key scanning. The block reports which slot is running and gives a one-cycle pulse when a new frame begins.

The segment pattern for each digit comes from a small display register file of ten bytes, read through an asynchronous read port. The digit's pattern is fetched during the last two sub-ticks of the slot before it. The fetched pattern and the brightness settings are loaded together at the slot boundary.

A 3-bit brightness code sets how long each grid stays on, counted in sixteenths of a slot and on a non-linear scale. For the rest of the slot, the grid and its segments are dark, which prevents ghosting. The display can be switched off. When it is off, every output is dark but the frame timing keeps running.

Top module: `led_mux_scan`

## Requirements
- R1: While reset is held, `grid_en` and `seg_en` are all zero, `frame_end` is 0 and `slot_idx` is 5. Brightness resets to code 000 and the display resets to off.
- R2: After reset, `slot_idx` starts at 5 and holds each value for 16 clocks, in the order 5, 0, 1, 2, 3, 4, 5, 0, and so on.
- R3: During slot n (0 to 4), only `grid_en[n]` may be high. During slot 5, no grid is high.
- R4: A grid is lit from sub-tick 0 for W sub-ticks of its slot. W depends on the brightness code: 000=1, 001=2, 010=4, 011=10, 100=11, 101=12, 110=13, 111=14.
- R5: While the display is off, all grid and segment enables stay low and the slot timing continues unchanged.
- R6: While digit n (1 to 5) is lit, the segment lines take their values from two bytes. `seg_en[7:0]` equals byte 2(n-1). `seg_en[9:8]` equals bits [1:0] of byte 2(n-1)+1. Bits [7:2] of the odd byte have no effect.
- R7: `ram_addr` always stays in the range 0 to 9. In the slot before digit n, it presents 2(n-1) at sub-tick 14 and 2(n-1)+1 at sub-tick 15. At all other sub-ticks, the value it presents has no effect.
- R8: Brightness code and display-on are sampled only in the last sub-tick of a slot. A change made in the middle of a slot does not alter the slot already in progress.
- R9: `frame_end` is high for exactly one clock, the first clock of slot 0.
- R10: Segment enables are all zero in every cycle in which no grid enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one sub-tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | Display on (1) or off (0), taken at slot boundaries |
| dim_code | input | 3 | Brightness code, taken at slot boundaries |
| ram_data | input | 8 | Read data of the display register file for `ram_addr` |
| ram_addr | output | 4 | Read address into the display register file |
| seg_en | output | 10 | Active-high segment enables |
| grid_en | output | 5 | Active-high grid enables |
| slot_idx | output | 3 | Current frame slot, 0 to 5 |
| frame_end | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The bench sweeps all eight brightness codes and counts the lit cycles of every grid over a full frame. A wrong entry in the on-time table would show up as a count that is off by one or more.

It changes the brightness in the middle of one slot and turns the display off in the middle of another. A design that applied settings at once would cut short or stretch the current pulse.

It loads bytes whose odd-address high bits are set and compares every segment line against the byte layout. This catches a swapped nibble, a segment wired to the wrong bit, or a digit fetched from the wrong address.

A per-cycle model also checks the slot order, the frame pulse position, the fetch addresses, and that segments stay dark whenever no grid is lit.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

   localparam int DIM_W = 3;

   typedef logic [DIM_W-1:0] dim_code_t;

   // On-time in sixteenths of a slot for each brightness code
   function automatic int dim_sixteenths(input dim_code_t code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 10;
         3'd4:    return 11;
         3'd5:    return 12;
         3'd6:    return 13;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
   parameter int SLOT_TICKS = 16,
   parameter int SLOT_COUNT = 6,
   localparam int SUB_W  = $clog2(SLOT_TICKS),
   localparam int SLOT_W = $clog2(SLOT_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SUB_W-1:0]  sub_q,
   output logic [SLOT_W-1:0] slot_q,
   output logic              slot_last,
   output logic              frame_end_q
);

   localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SLOT_TICKS - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_COUNT - 1);

   assign slot_last = (sub_q == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q       <= '0;
         slot_q      <= SLOT_LAST;
         frame_end_q <= 1'b0;
      end else begin
         frame_end_q <= slot_last && (slot_q == SLOT_LAST);
         if (slot_last) begin
            sub_q  <= '0;
            slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
         end else begin
            sub_q  <= sub_q + 1'b1;
         end
      end
   end

   p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= SLOT_LAST);

   p_sub_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_last |=> (sub_q == '0));

   p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> $stable(slot_q));

endmodule

// File: rtl/seg_fetch.sv
module seg_fetch #(
   parameter int NUM_GRIDS  = 5,
   parameter int SLOT_TICKS = 16,
   parameter int NUM_SEGS   = 10,
   parameter int BYTE_W     = 8,
   localparam int SLOT_COUNT = NUM_GRIDS + 1,
   localparam int SUB_W      = $clog2(SLOT_TICKS),
   localparam int SLOT_W     = $clog2(SLOT_COUNT),
   localparam int ADDR_W     = $clog2(2 * NUM_GRIDS),
   localparam int ODD_BITS   = NUM_SEGS - BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SUB_W-1:0]    sub_q,
   input  logic [SLOT_W-1:0]   slot_q,
   input  logic                slot_last,
   input  logic [BYTE_W-1:0]   ram_data,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic [NUM_SEGS-1:0] pattern_q
);

   localparam logic [SUB_W-1:0]  SUB_FETCH_LO = SUB_W'(SLOT_TICKS - 2);
   localparam logic [SLOT_W-1:0] SLOT_LAST    = SLOT_W'(SLOT_COUNT - 1);

   logic [SLOT_W-1:0]   next_slot;
   logic                next_is_digit;
   logic                fetch_lo;
   logic [BYTE_W-1:0]   lo_byte_q;
   logic [NUM_SEGS-1:0] assembled;
   logic                unused_odd_bits;

   assign next_slot     = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
   assign next_is_digit = (next_slot < SLOT_W'(NUM_GRIDS));
   assign fetch_lo      = (sub_q == SUB_FETCH_LO);

   // Even byte at the second-to-last sub-tick, odd byte at the last one
   assign ram_addr = next_is_digit
                   ? ((ADDR_W'(next_slot) << 1) | ADDR_W'(slot_last))
                   : '0;

   // Segment layout: a full even byte, then the low bits of the odd byte
   for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg_map
      if (s < BYTE_W) begin : g_even
         assign assembled[s] = lo_byte_q[s];
      end else begin : g_odd
         assign assembled[s] = ram_data[s - BYTE_W];
      end
   end

   assign unused_odd_bits = ^ram_data[BYTE_W-1:ODD_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_byte_q <= '0;
         pattern_q <= '0;
      end else begin
         if (fetch_lo && next_is_digit) begin
            lo_byte_q <= ram_data;
         end
         if (slot_last) begin
            pattern_q <= next_is_digit ? assembled : '0;
         end
      end
   end

   p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_addr < ADDR_W'(2 * NUM_GRIDS));

   p_odd_at_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last && next_is_digit) |-> ram_addr[0]);

   p_pattern_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> $stable(pattern_q));

endmodule

// File: rtl/pulse_gate.sv
module pulse_gate
   import led_scan_pkg::*;
#(
   parameter int NUM_GRIDS  = 5,
   parameter int SLOT_TICKS = 16,
   parameter int NUM_SEGS   = 10,
   localparam int SLOT_COUNT = NUM_GRIDS + 1,
   localparam int SUB_W      = $clog2(SLOT_TICKS),
   localparam int SLOT_W     = $clog2(SLOT_COUNT),
   localparam int WID_W      = SUB_W + 1,
   localparam int SCALE      = SLOT_TICKS / 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SUB_W-1:0]     sub_q,
   input  logic [SLOT_W-1:0]    slot_q,
   input  logic                 slot_last,
   input  logic                 disp_on,
   input  dim_code_t            dim_code,
   input  logic [NUM_SEGS-1:0]  pattern_q,
   output logic [NUM_GRIDS-1:0] grid_en,
   output logic [NUM_SEGS-1:0]  seg_en
);

   logic [WID_W-1:0] width_q;
   logic             on_q;
   logic             in_pulse;
   logic             lit;

   // Settings change only at a slot boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= WID_W'(dim_sixteenths(3'd0) * SCALE);
         on_q    <= 1'b0;
      end else if (slot_last) begin
         width_q <= WID_W'(dim_sixteenths(dim_code) * SCALE);
         on_q    <= disp_on;
      end
   end

   assign in_pulse = on_q && ({1'b0, sub_q} < width_q);

   for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
      assign grid_en[g] = in_pulse && (slot_q == SLOT_W'(g));
   end

   assign lit    = |grid_en;
   assign seg_en = lit ? pattern_q : '0;

   p_grid_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grid_en));

   p_off_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !on_q |-> (grid_en == '0));

   p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q != '0) |-> ($stable(width_q) && $stable(on_q)));

   p_seg_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grid_en == '0) |-> (seg_en == '0));

endmodule

// File: rtl/led_mux_scan.sv
module led_mux_scan
   import led_scan_pkg::*;
#(
   parameter int NUM_GRIDS  = 5,
   parameter int NUM_SEGS   = 10,
   parameter int BYTE_W     = 8,
   parameter int SLOT_TICKS = 16,
   localparam int SLOT_COUNT = NUM_GRIDS + 1,
   localparam int SUB_W      = $clog2(SLOT_TICKS),
   localparam int SLOT_W     = $clog2(SLOT_COUNT),
   localparam int ADDR_W     = $clog2(2 * NUM_GRIDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_on,
   input  logic [DIM_W-1:0]     dim_code,
   input  logic [BYTE_W-1:0]    ram_data,
   output logic [ADDR_W-1:0]    ram_addr,
   output logic [NUM_SEGS-1:0]  seg_en,
   output logic [NUM_GRIDS-1:0] grid_en,
   output logic [SLOT_W-1:0]    slot_idx,
   output logic                 frame_end
);

   if (SLOT_TICKS % 16 != 0) begin : g_bad_ticks
      $error("SLOT_TICKS must be a multiple of 16");
   end
   if (NUM_SEGS <= BYTE_W || NUM_SEGS > 2 * BYTE_W) begin : g_bad_segs
      $error("NUM_SEGS must span one byte plus part of a second");
   end
   if (NUM_GRIDS < 1) begin : g_bad_grids
      $error("NUM_GRIDS must be at least 1");
   end

   logic [SUB_W-1:0]    sub_q;
   logic [SLOT_W-1:0]   slot_q;
   logic                slot_last;
   logic [NUM_SEGS-1:0] pattern_q;

   scan_timer #(
      .SLOT_TICKS (SLOT_TICKS),
      .SLOT_COUNT (SLOT_COUNT)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .sub_q       (sub_q),
      .slot_q      (slot_q),
      .slot_last   (slot_last),
      .frame_end_q (frame_end)
   );

   seg_fetch #(
      .NUM_GRIDS  (NUM_GRIDS),
      .SLOT_TICKS (SLOT_TICKS),
      .NUM_SEGS   (NUM_SEGS),
      .BYTE_W     (BYTE_W)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_q     (sub_q),
      .slot_q    (slot_q),
      .slot_last (slot_last),
      .ram_data  (ram_data),
      .ram_addr  (ram_addr),
      .pattern_q (pattern_q)
   );

   pulse_gate #(
      .NUM_GRIDS  (NUM_GRIDS),
      .SLOT_TICKS (SLOT_TICKS),
      .NUM_SEGS   (NUM_SEGS)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_q     (sub_q),
      .slot_q    (slot_q),
      .slot_last (slot_last),
      .disp_on   (disp_on),
      .dim_code  (dim_code),
      .pattern_q (pattern_q),
      .grid_en   (grid_en),
      .seg_en    (seg_en)
   );

   assign slot_idx = slot_q;

   p_no_grid_blank_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_W'(NUM_GRIDS)) |-> (grid_en == '0));

   p_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> ((slot_q == '0) && (sub_q == '0)));

   p_frame_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);

endmodule

// File: tb/led_mux_scan_bench.sv
module led_mux_scan_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       disp_on = 1'b0;
   logic [2:0] dim_code = 3'd0;
   logic [7:0] ram_data;
   logic [3:0] ram_addr;
   logic [9:0] seg_en;
   logic [4:0] grid_en;
   logic [2:0] slot_idx;
   logic       frame_end;

   logic [7:0] mem [0:9];

   int checks = 0;
   int errors = 0;

   // Reference model state, advanced at each falling edge
   int         m_slot = 5;
   int         m_sub  = 0;
   int         m_w    = 1;
   logic       m_on   = 1'b0;
   logic [9:0] m_pat  = '0;
   logic       m_fe   = 1'b0;

   always #5 clk = ~clk;

   assign ram_data = (ram_addr < 4'd10) ? mem[ram_addr] : 8'h00;

   led_mux_scan u_led_mux_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .disp_on   (disp_on),
      .dim_code  (dim_code),
      .ram_data  (ram_data),
      .ram_addr  (ram_addr),
      .seg_en    (seg_en),
      .grid_en   (grid_en),
      .slot_idx  (slot_idx),
      .frame_end (frame_end)
   );

   function automatic int exp_width(input logic [2:0] c);
      case (c)
         3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 10;
         3'd4: return 11; 3'd5: return 12; 3'd6: return 13; default: return 14;
      endcase
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_slot = 5; m_sub = 0; m_w = 1; m_on = 1'b0; m_pat = '0; m_fe = 1'b0;
      end else if (m_sub == 15) begin
         m_w    = exp_width(dim_code);
         m_on   = disp_on;
         m_fe   = (m_slot == 5);
         m_slot = (m_slot == 5) ? 0 : m_slot + 1;
         m_pat  = (m_slot < 5) ? {mem[2*m_slot+1][1:0], mem[2*m_slot]} : 10'd0;
         m_sub  = 0;
      end else begin
         m_sub = m_sub + 1;
         m_fe  = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic drive_wait();
      @(negedge clk); #1;
   endtask

   // Compare every output against the model for n cycles
   task automatic check_cycles(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [4:0] eg;
         logic [9:0] es;
         int         nx;
         logic [3:0] ea;
         step();
         eg = (m_slot < 5 && m_on && m_sub < m_w) ? 5'(1 << m_slot) : 5'd0;
         es = (eg != 0) ? m_pat : 10'd0;
         nx = (m_slot == 5) ? 0 : m_slot + 1;
         ea = (nx < 5) ? 4'(2*nx + ((m_sub == 15) ? 1 : 0)) : 4'd0;
         chk(grid_en == eg, tag, "R3 R4 grid_en", grid_en, eg);
         chk(seg_en == es, tag, "R6 seg_en", seg_en, es);
         chk(grid_en != 0 || seg_en == 0, tag, "R10 blank", seg_en, 0);
         chk(slot_idx == 3'(m_slot), tag, "R2 slot_idx", slot_idx, m_slot);
         chk(frame_end == m_fe, tag, "R9 frame_end", frame_end, m_fe);
         if (m_sub >= 14 && nx < 5)
            chk(ram_addr == ea, tag, "R7 ram_addr", ram_addr, ea);
         chk(ram_addr <= 4'd9, tag, "R7 ram_addr range", ram_addr, 9);
      end
   endtask

   task automatic wait_frame_start();
      do step(); while (!frame_end);
   endtask

   task automatic load_mem(input logic [7:0] seed);
      while (m_sub >= 12) step();
      for (int a = 0; a < 10; a++)
         mem[a] = (a % 2 == 1) ? (8'hFC | 8'(seed + a)) : 8'(seed * 3 + a * 37);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 3; i++) begin
         step();
         chk(grid_en == 0, "R1", "grid_en", grid_en, 0);
         chk(seg_en == 0, "R1", "seg_en", seg_en, 0);
         chk(slot_idx == 3'd5, "R1", "slot_idx", slot_idx, 5);
         chk(frame_end == 1'b0, "R1", "frame_end", frame_end, 0);
      end
      drive_wait();
      rst_n = 1'b1;
      check_cycles(20, "R1 R2");
   endtask

   task automatic t_display_off();
      drive_wait();
      disp_on = 1'b0;
      dim_code = 3'd7;
      check_cycles(2 * 96, "R5");
   endtask

   task automatic t_dim_sweep();
      for (int c = 0; c < 8; c++) begin
         int cnt [5];
         drive_wait();
         disp_on = 1'b1;
         dim_code = 3'(c);
         wait_frame_start();
         for (int g = 0; g < 5; g++) cnt[g] = 0;
         for (int i = 0; i < 96; i++) begin
            for (int g = 0; g < 5; g++) if (grid_en[g]) cnt[g]++;
            if (i != 95) step();
         end
         for (int g = 0; g < 5; g++)
            chk(cnt[g] == exp_width(3'(c)), "R4", $sformatf("on-time grid %0d code %0d", g, c),
                cnt[g], exp_width(3'(c)));
      end
   endtask

   task automatic t_seg_map();
      load_mem(8'h15);
      drive_wait();
      disp_on = 1'b1;
      dim_code = 3'd7;
      check_cycles(2 * 96, "R6");
      load_mem(8'hA2);
      check_cycles(2 * 96, "R6 R7");
   endtask

   task automatic t_mid_slot_change();
      int c1, c2, c3, c4;
      drive_wait();
      disp_on = 1'b1;
      dim_code = 3'd7;
      wait_frame_start();
      c1 = 0; c2 = 0; c3 = 0; c4 = 0;
      for (int i = 0; i < 96; i++) begin
         if (grid_en[1]) c1++;
         if (grid_en[2]) c2++;
         if (grid_en[3]) c3++;
         if (grid_en[4]) c4++;
         if (i == 16 + 3) dim_code = 3'd0;
         if (i == 48 + 2) disp_on = 1'b0;
         if (i != 95) step();
      end
      chk(c1 == 14, "R8", "grid 1 on-time after mid-slot dim change", c1, 14);
      chk(c2 == 1, "R8", "grid 2 on-time with new code", c2, 1);
      chk(c3 == 1, "R8", "grid 3 on-time despite mid-slot off", c3, 1);
      chk(c4 == 0, "R8 R5", "grid 4 dark after off", c4, 0);
      check_cycles(96, "R8");
   endtask

   task automatic t_frame_pulse();
      int pulses;
      drive_wait();
      disp_on = 1'b1;
      dim_code = 3'd3;
      pulses = 0;
      for (int i = 0; i < 3 * 96; i++) begin
         step();
         if (frame_end) begin
            pulses++;
            chk(slot_idx == 3'd0, "R9", "slot at pulse", slot_idx, 0);
         end
      end
      chk(pulses == 3, "R9", "pulses in three frames", pulses, 3);
   endtask

   initial begin
      for (int a = 0; a < 10; a++) mem[a] = 8'(a * 29 + 7);
      t_reset();
      t_display_off();
      t_dim_sweep();
      t_seg_map();
      t_mid_slot_change();
      t_frame_pulse();
      check_cycles(96, "R10");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule